// File: doc/BRIEF.md
# Prescaled Interval Timer

A register-programmed interval timer for a bus clock domain. A clock divider with a 16-bit ratio feeds a 16-bit period down-counter, so one expiry spans up to 2^32 bus clocks. Software programs the divider ratio and the period as one packed word, then sets a control word. The control word starts and stops counting, selects single-shot or free-running operation, and gates the interrupt.

Every expiry latches a pending flag. The interrupt line is high while a pending flag is latched and the interrupt gate is open. Software clears the flag by writing a one to it. In single-shot mode the hardware drops the run bit when the timer expires. In free-running mode the counters reload themselves and keep going.

Access is a plain write strobe with a 2-bit address and 32-bit write data. Read data is registered and follows the address.

Top module: `ivt_core`

## Requirements
- R1: After reset, the control, count and status registers are all 0 and `irq_o` is low.
- R2: Register map:
  - Address 0 is control: bit 12 run, bit 10 free-running, bit 8 interrupt gate. All other bits read 0.
  - Address 1 is count: bits 31:16 are the divider ratio and bits 15:0 the period. It reads back as written.
  - Address 2 is status: bit 0 is the expiry flag and bits 3:1 read 0.
  - Address 3 reads 0.
  - `reg_rdata` holds the value for the address sampled at the previous rising edge.
- R3: If the run bit is written to 1 at edge k, with ratio P and period C, the first expiry sets status bit 0 at edge k+P*C and not before.
- R4: In free-running mode the timer expires again every P*C edges and the run bit stays set.
- R5: In single-shot mode the hardware clears the run bit at the expiry edge. The free-running and gate bits keep their values.
- R6: After a single-shot expiry, no further expiry occurs until software sets the run bit again.
- R7: Writing status clears each bit written as 1. Bits written as 0 are unchanged. An expiry on the same edge wins over the clear.
- R8: `irq_o` equals (any status bit set) AND the gate bit, updated on the same edge as those registers. With the gate clear, an expiry sets the flag but `irq_o` stays low.
- R9: Writing the run bit to 0 stops counting. A later start counts a full P*C period again.
- R10: Writing the count register while running reloads both counters with the new values at the write edge. The next expiry then comes P*C edges later.
- R11: A divider ratio of 0 divides by 65536.
- R12: A period of 0 counts 65536 divided ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Writes take effect at the edge that samples the strobe. An expiry is due exactly P*C edges after the edge that wrote the run bit or the count word. `irq_o` follows on that same edge, and read data comes one edge after the address. The bench drives and samples on falling edges. It waits a counted number of rising edges after each write, checks `irq_o` low one edge before the due edge, and checks it high on the due edge. Register contents are read only outside those windows, so the read latency never shifts the timing being checked.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  localparam int RUN_BIT  = 12;
  localparam int FREE_BIT = 10;
  localparam int GATE_BIT = 8;

  typedef struct packed {
    logic run;
    logic free;
    logic gate;
  } ctrl_t;
endpackage

// File: rtl/ivt_downcnt.sv
`timescale 1ns/1ps
// One-based reloading down-counter: a value of 0 counts 2**W steps.
module ivt_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] val,
  output logic         done
);
  localparam int            CW   = W + 1;
  localparam logic [CW-1:0] FULL = {1'b1, {W{1'b0}}};
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] start;

  assign start = (val == '0) ? FULL : {1'b0, val};
  assign done  = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= FULL;
    else if (load) cnt_q <= start;
    else if (step) cnt_q <= done ? start : cnt_q - ONE;
  end
endmodule

// File: rtl/ivt_regs.sv
`timescale 1ns/1ps
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_count,
  input  logic              wr_stat,
  input  logic [1:0]        rd_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] count_src,
  output logic [STAT_W-1:0] stat_q,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [STAT_W-1:0] stat_d;
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run  = wdata[RUN_BIT];
      ctrl_d.free = wdata[FREE_BIT];
      ctrl_d.gate = wdata[GATE_BIT];
    end else if (expire && !ctrl_q.free) begin
      ctrl_d.run = 1'b0;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_q & ~wdata[STAT_W-1:0];
    if (expire)  stat_d[0] = 1'b1;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[RUN_BIT]  = ctrl_q.run;
    ctrl_word[FREE_BIT] = ctrl_q.free;
    ctrl_word[GATE_BIT] = ctrl_q.gate;
  end

  assign count_src = wr_count ? wdata : count_q;
  assign ctrl      = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      count_q <= '0;
      stat_q  <= '0;
      rdata   <= '0;
      irq     <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      irq    <= (|stat_d) && ctrl_d.gate;
      if (wr_count) count_q <= wdata;
      case (reg_addr_e'(rd_addr))
        ADDR_CTRL:  rdata <= ctrl_word;
        ADDR_COUNT: rdata <= count_q;
        ADDR_STAT:  rdata <= DATA_W'(stat_q);
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivt_core.sv
`timescale 1ns/1ps
module ivt_core
  import ivt_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int PER_W  = 16,
  parameter int STAT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [PRE_W+PER_W-1:0] reg_wdata,
  output logic [PRE_W+PER_W-1:0] reg_rdata,
  output logic                   irq_o
);
  localparam int DATA_W = PRE_W + PER_W;

  logic              wr_ctrl, wr_count, wr_stat;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] count_q, count_src;
  logic [STAT_W-1:0] stat_q;
  logic              run, load, tick, expire;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_count = reg_wr && (reg_addr == ADDR_COUNT);
  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);

  assign load = wr_count || !ctrl.run;
  assign run  = ctrl.run && !wr_count;

  ivt_regs #(.DATA_W(DATA_W), .STAT_W(STAT_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_ctrl), .wr_count(wr_count), .wr_stat(wr_stat),
    .rd_addr(reg_addr), .wdata(reg_wdata), .expire(expire),
    .ctrl(ctrl), .count_q(count_q), .count_src(count_src),
    .stat_q(stat_q), .rdata(reg_rdata), .irq(irq_o)
  );

  ivt_downcnt #(.W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .load(load), .step(run),
    .val(count_src[DATA_W-1:PER_W]), .done(tick)
  );

  ivt_downcnt #(.W(PER_W)) per_i (
    .clk(clk), .rst(rst), .load(load), .step(tick),
    .val(count_src[PER_W-1:0]), .done(expire)
  );
endmodule

// File: rtl/ivt_core_chk.sv
`timescale 1ns/1ps
module ivt_core_chk #(
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              free,
  input logic              gate,
  input logic              wr_ctrl,
  input logic              expire,
  input logic [STAT_W-1:0] stat_q,
  input logic              irq_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && !irq_o && !run));

  a_r2_upper_status_zero: assert property (@(posedge clk) disable iff (rst)
    stat_q[STAT_W-1:1] == '0);

  a_r3_expire_sets_pending: assert property (@(posedge clk) disable iff (rst)
    expire |=> stat_q[0]);

  a_r4_free_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (expire && free && !wr_ctrl) |=> run);

  a_r5_single_drops_run: assert property (@(posedge clk) disable iff (rst)
    (expire && !free && !wr_ctrl) |=> !run);

  a_r6_idle_no_expiry: assert property (@(posedge clk) disable iff (rst)
    !run |-> !expire);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((|stat_q) && gate));
endmodule

bind ivt_core ivt_core_chk #(.STAT_W(STAT_W)) chk_i (
  .clk(clk), .rst(rst), .run(ctrl.run), .free(ctrl.free), .gate(ctrl.gate),
  .wr_ctrl(wr_ctrl), .expire(expire), .stat_q(stat_q), .irq_o(irq_o)
);

// File: tb/ivt_core_tb_top.sv
`timescale 1ns/1ps
module ivt_core_tb_top;
  localparam logic [31:0] M_RUN  = 32'h0000_1000;
  localparam logic [31:0] M_FREE = 32'h0000_0400;
  localparam logic [31:0] M_GATE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ivt_core dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_e(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "irq after reset", 32'(irq_o), 0);
    rd(2'd0, d); chk("R1", "ctrl after reset", d, 0);
    rd(2'd1, d); chk("R1", "count after reset", d, 0);
    rd(2'd2, d); chk("R1", "status after reset", d, 0);
    rd(2'd3, d); chk("R2", "unused address", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_EFFF);
    rd(2'd0, d); chk("R2", "ctrl unused bits", d, M_FREE | M_GATE);
    wr(2'd0, 0);
    wr(2'd1, 32'hA5C3_1234);
    rd(2'd1, d); chk("R2", "count readback", d, 32'hA5C3_1234);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(2'd1, {16'd3, 16'd4});
    wr(2'd0, M_RUN | M_GATE);
    wait_e(11); chk("R3", "irq before P*C", 32'(irq_o), 0);
    wait_e(1);  chk("R3", "irq at P*C", 32'(irq_o), 1);
    rd(2'd0, d); chk("R5", "run cleared, gate kept", d, M_GATE);
    rd(2'd2, d); chk("R3", "status flag", d, 1);
    wr(2'd2, 0);
    rd(2'd2, d); chk("R7", "write 0 keeps flag", d, 1);
    wr(2'd2, 1);
    chk("R7", "irq after clear", 32'(irq_o), 0);
    wait_e(40); chk("R6", "no refire", 32'(irq_o), 0);
    rd(2'd2, d); chk("R6", "status stays clear", d, 0);
  endtask

  task automatic t_free();
    logic [31:0] d;
    wr(2'd1, {16'd2, 16'd5});
    wr(2'd0, M_RUN | M_FREE | M_GATE);
    wait_e(9); chk("R4", "irq before first", 32'(irq_o), 0);
    wait_e(1); chk("R4", "first expiry", 32'(irq_o), 1);
    wr(2'd2, 1);
    chk("R7", "cleared between expiries", 32'(irq_o), 0);
    wait_e(8); chk("R4", "irq before second", 32'(irq_o), 0);
    wait_e(1); chk("R4", "second expiry", 32'(irq_o), 1);
    rd(2'd0, d); chk("R4", "run stays set", d, M_RUN | M_FREE | M_GATE);
    wr(2'd0, 0); wr(2'd2, 1);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(2'd1, {16'd1, 16'd3});
    wr(2'd0, M_RUN | M_FREE);
    wait_e(3); chk("R8", "irq gated off", 32'(irq_o), 0);
    rd(2'd2, d); chk("R8", "flag set while gated", d, 1);
    wr(2'd0, M_RUN | M_FREE | M_GATE);
    chk("R8", "irq on gate open", 32'(irq_o), 1);
    wr(2'd0, 0); wr(2'd2, 32'hF);
    chk("R8", "irq low after clear", 32'(irq_o), 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(2'd1, {16'd1, 16'd10});
    wr(2'd0, M_RUN | M_GATE);
    wait_e(5);
    wr(2'd0, M_GATE);
    wait_e(30); chk("R9", "stopped no irq", 32'(irq_o), 0);
    rd(2'd2, d); chk("R9", "stopped no flag", d, 0);
    wr(2'd0, M_RUN | M_GATE);
    wait_e(9); chk("R9", "restart before full", 32'(irq_o), 0);
    wait_e(1); chk("R9", "restart full period", 32'(irq_o), 1);
    wr(2'd2, 1);
  endtask

  task automatic t_reload();
    wr(2'd1, {16'd1, 16'd10});
    wr(2'd0, M_RUN | M_GATE);
    wait_e(4);
    wr(2'd1, {16'd1, 16'd4});
    wait_e(3); chk("R10", "before reloaded expiry", 32'(irq_o), 0);
    wait_e(1); chk("R10", "reloaded expiry", 32'(irq_o), 1);
    wr(2'd2, 1);
  endtask

  task automatic t_min();
    wr(2'd1, {16'd1, 16'd1});
    wr(2'd0, M_RUN | M_GATE);
    chk("R3", "1x1 not yet", 32'(irq_o), 0);
    wait_e(1); chk("R3", "1x1 after one edge", 32'(irq_o), 1);
    wr(2'd2, 1);
  endtask

  task automatic t_zero_div();
    wr(2'd1, {16'd0, 16'd1});
    wr(2'd0, M_RUN | M_GATE);
    wait_e(65535); chk("R11", "ratio 0 early", 32'(irq_o), 0);
    wait_e(1);     chk("R11", "ratio 0 = 65536", 32'(irq_o), 1);
    wr(2'd2, 1);
  endtask

  task automatic t_zero_per();
    wr(2'd1, {16'd1, 16'd0});
    wr(2'd0, M_RUN | M_GATE);
    wait_e(65535); chk("R12", "period 0 early", 32'(irq_o), 0);
    wait_e(1);     chk("R12", "period 0 = 65536", 32'(irq_o), 1);
    wr(2'd2, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_single();
    t_free();
    t_gate();
    t_stop();
    t_reload();
    t_min();
    t_zero_div();
    t_zero_per();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule